// File: doc/BRIEF.md
# Write-Lockable PLL Divider Configuration Register

This block is a 16-bit memory-mapped control word that feeds a pair of divider values, a 4-bit Q and an 8-bit P, to a dual-modulus PLL feedback counter. Software programs the pair through a small write port with two byte enables. The new pair is accepted only when it lies inside the legal operating ranges. A pair outside those ranges is turned away whole, and a sticky error flag records that this happened.

A protect bit can be written to 1 by software and is cleared only by reset. While it is set, the divider fields are frozen. The top bit of the read word shows the live level of a slow asynchronous reference clock, after a two-stage synchronizer in the bus clock domain. Read data always reflects the current state. Configuration is meant to be written as a whole word, but either byte may be written alone.

Top module: `pllcfg_reg`

## Requirements
- R1: Read bit 15 shows the level of `ref_slow` (0 low, 1 high) through a two-flop synchronizer. A level held before a rising bus clock edge appears on `rdata[15]` after the second rising edge.
- R2: After reset the read word is 0x0347: `q_div` = 3, `p_div` = 0x47, protect bit 0 and `cfg_err` = 0.
- R3: Q sits at `rdata[11:8]`, P at `rdata[7:0]` and the protect bit at `rdata[14]`. The `q_div` and `p_div` outputs equal the stored fields.
- R4: Bits 13:12 of the read word are always 0, whatever value is written to them.
- R5: Writing 1 to bit 14 sets the protect bit. Writing 0 to it has no effect, and only reset clears it.
- R6: While the protect bit is 1, writes to Q and P are ignored, both fields keep their values, and `cfg_err` does not change.
- R7: An unprotected word write (`be`=2'b11) with a legal pair updates both fields. If the same write also sets the protect bit, the new pair is stored, and the lock applies from the next cycle onward.
- R8: A pair is legal when 1 < Q < 14 and P > Q + 1. An unprotected write that would produce an illegal pair changes neither field and sets `cfg_err`, which stays at 1 until reset.
- R9: `be[1]` enables the upper byte (protect bit and Q) and `be[0]` enables the lower byte (P). A single-byte write is checked against the stored value of the other field.
- R10: A write takes effect only on a cycle with both `cs` and `wr_en` high. At any other time the stored state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Register select |
| wr_en | input | 1 | Write strobe |
| be | input | 2 | Byte enables: [1] upper, [0] lower |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read word: status, protect, zeros, Q, P |
| ref_slow | input | 1 | Asynchronous slow reference clock |
| q_div | output | 4 | Q divider value to the PLL |
| p_div | output | 8 | P divider value to the PLL |
| cfg_err | output | 1 | Sticky flag: a write with an illegal pair was rejected |

## Verification
The bench probes the edges of the legal range on each side. Q = 1 and Q = 14 must be turned away, and P = Q + 1 must be rejected while P = Q + 2 is accepted. A design with an off-by-one comparison would store a pair that the PLL cannot use. Single-byte writes are checked against the stored other field, so a design that checked against the write data of the disabled byte would accept or reject the wrong values. The bench also writes 0 to a set protect bit and writes dividers while locked, which catches a lock that can be cleared or is leaky. It sets the lock and a new pair in the same word to confirm the pair lands, and it writes ones to the reserved bits to confirm they read back as 0. The synchronizer delay is sampled one edge early and again on the expected edge, so a stage count that is wrong in either direction shows up.

// File: rtl/pllcfg_pkg.sv
// Package: shared widths, field positions and reset values for the
// PLL divider configuration register. Assumes a 16-bit register layout.
package pllcfg_pkg;
    localparam int unsigned REG_W   = 16;
    localparam int unsigned Q_W     = 4;
    localparam int unsigned P_W     = 8;
    localparam int unsigned BIT_REF = 15;
    localparam int unsigned BIT_PROT = 14;
    localparam int unsigned Q_LSB   = 8;
    localparam int unsigned P_LSB   = 0;
    localparam logic [Q_W-1:0] Q_RESET = 4'd3;
    localparam logic [P_W-1:0] P_RESET = 8'h47;
    localparam int unsigned Q_MIN_EXCL = 1;
    localparam int unsigned Q_MAX_EXCL = 14;
endpackage

// File: rtl/pllcfg_sync.sv
// Multi-stage synchronizer that carries an asynchronous level into the
// clock domain of clk. Assumes the input is a slow level signal, so no
// pulse stretching is needed. Reset drives every stage to 0.
module pllcfg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] stage_q;

    // Shift the sampled level along the chain on each clock.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pllcfg_range.sv
// Combinational legality check for a candidate divider pair. A pair is
// legal when Q lies strictly between the two bounds and P exceeds Q + 1.
// Assumes Q_W + 1 <= P_W + 1, so Q + 1 fits the widened comparison.
module pllcfg_range #(
    parameter int unsigned Q_W  = 4,
    parameter int unsigned P_W  = 8,
    parameter int unsigned Q_LO = 1,
    parameter int unsigned Q_HI = 14
) (
    input  logic [Q_W-1:0] q_cand,
    input  logic [P_W-1:0] p_cand,
    output logic           pair_ok
);
    localparam int unsigned CW = (P_W > Q_W ? P_W : Q_W) + 1;
    logic [CW-1:0] q_ext;
    logic [CW-1:0] p_ext;
    logic [CW-1:0] q_plus1;
    logic          q_ok;
    logic          p_ok;

    // Widen both fields and evaluate the three bounds.
    always_comb begin
        q_ext   = CW'(q_cand);
        p_ext   = CW'(p_cand);
        q_plus1 = q_ext + CW'(1);
        q_ok    = (q_ext > CW'(Q_LO)) && (q_ext < CW'(Q_HI));
        p_ok    = p_ext > q_plus1;
        pair_ok = q_ok && p_ok;
    end
endmodule

// File: rtl/pllcfg_fields.sv
// Storage for the protect bit, the Q and P fields and the sticky error
// flag. It merges byte-enabled write data with the stored values, and the
// range checker judges the merged pair. The protect bit is judged before
// the write, so a write that sets it still lands its own Q/P pair.
module pllcfg_fields
    import pllcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [1:0]       be,
    input  logic [REG_W-1:0] wdata,
    output logic [Q_W-1:0]   q_val,
    output logic [P_W-1:0]   p_val,
    output logic             prot,
    output logic             err
);
    logic [Q_W-1:0] q_cand;
    logic [P_W-1:0] p_cand;
    logic           pair_ok;
    logic           fld_wr;

    // Merge enabled bytes of the write with the stored fields.
    always_comb begin
        q_cand = be[1] ? wdata[Q_LSB +: Q_W] : q_val;
        p_cand = be[0] ? wdata[P_LSB +: P_W] : p_val;
        fld_wr = wr_stb && (be != 2'b00) && !prot;
    end

    pllcfg_range #(
        .Q_W (Q_W),
        .P_W (P_W),
        .Q_LO(Q_MIN_EXCL),
        .Q_HI(Q_MAX_EXCL)
    ) u_range (
        .q_cand (q_cand),
        .p_cand (p_cand),
        .pair_ok(pair_ok)
    );

    // Protect bit: set by an upper-byte write of 1, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   prot <= 1'b0;
        else if (wr_stb && be[1] && wdata[BIT_PROT]) prot <= 1'b1;
    end

    // Divider fields: load a legal merged pair when unprotected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_val <= Q_RESET;
            p_val <= P_RESET;
        end else if (fld_wr && pair_ok) begin
            q_val <= q_cand;
            p_val <= p_cand;
        end
    end

    // Sticky error: set when an unprotected write brings an illegal pair.
    always_ff @(posedge clk) begin
        if (!rst_n)                  err <= 1'b0;
        else if (fld_wr && !pair_ok) err <= 1'b1;
    end
endmodule

// File: rtl/pllcfg_reg.sv
// Top of the PLL divider configuration register. It joins the write
// qualifier, the field storage and the reference synchronizer, and it
// assembles the read word. Reserved bits are tied to 0. Read data is
// available at all times and does not depend on cs.
module pllcfg_reg
    import pllcfg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             wr_en,
    input  logic [1:0]       be,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             ref_slow,
    output logic [Q_W-1:0]   q_div,
    output logic [P_W-1:0]   p_div,
    output logic             cfg_err
);
    logic wr_stb;
    logic ref_sync;
    logic prot;

    // Qualify the write strobe with the select.
    assign wr_stb = cs && wr_en;

    pllcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ref_slow),
        .sync_out(ref_sync)
    );

    pllcfg_fields u_fields (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_stb(wr_stb),
        .be    (be),
        .wdata (wdata),
        .q_val (q_div),
        .p_val (p_div),
        .prot  (prot),
        .err   (cfg_err)
    );

    // Assemble the read word; unlisted bits stay 0.
    always_comb begin
        rdata                 = '0;
        rdata[BIT_REF]        = ref_sync;
        rdata[BIT_PROT]       = prot;
        rdata[Q_LSB +: Q_W]   = q_div;
        rdata[P_LSB +: P_W]   = p_div;
    end
endmodule

// File: rtl/pllcfg_reg_sva.sv
// Checker for pllcfg_reg, attached by bind. It watches only top-level
// ports and assumes the synchronous active-low reset.
module pllcfg_reg_sva (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] rdata,
    input logic [3:0]  q_div,
    input logic [7:0]  p_div,
    input logic        cfg_err
);
    // R5: protect bit never falls outside reset.
    a_r5_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[14] |=> rdata[14]);

    // R6: fields hold while protected.
    a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[14] |=> ($stable(q_div) && $stable(p_div) && $stable(cfg_err)));

    // R4: reserved bits read 0.
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[13:12] == 2'b00);

    // R8: stored pair always legal.
    a_r8_pair_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (q_div > 4'd1) && (q_div < 4'd14) && ({1'b0, p_div} > ({5'b0, q_div} + 9'd1)));

    // R8: error flag is sticky.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R8: the rejecting write leaves fields untouched.
    a_r8_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> ($stable(q_div) && $stable(p_div)));

    // R3: outputs mirror the read word fields.
    a_r3_fields_match: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[11:8] == q_div) && (rdata[7:0] == p_div));
endmodule

bind pllcfg_reg pllcfg_reg_sva u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .rdata  (rdata),
    .q_div  (q_div),
    .p_div  (p_div),
    .cfg_err(cfg_err)
);

// File: tb/pllcfg_reg_bench.sv
module pllcfg_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  be = 2'b00;
    logic [15:0] wdata = 16'h0;
    logic        ref_slow = 1'b0;
    logic [15:0] rdata;
    logic [3:0]  q_div;
    logic [7:0]  p_div;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;
    logic exp_err = 1'b0;
    logic exp_prot = 1'b0;

    always #2.5 clk = ~clk;

    pllcfg_reg u_pllcfg_reg (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .be(be),
        .wdata(wdata), .rdata(rdata), .ref_slow(ref_slow),
        .q_div(q_div), .p_div(p_div), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Compare full state with the model values (ref level low in these tests).
    task automatic check_state(input string req, input logic [3:0] q, input logic [7:0] p);
        check(req, {16'h0, rdata}, {16'h0, 1'b0, exp_prot, 2'b00, q, p});
        check(req, {28'h0, q_div}, {28'h0, q});
        check(req, {24'h0, p_div}, {24'h0, p});
        check(req, {31'h0, cfg_err}, {31'h0, exp_err});
    endtask

    task automatic do_write(input logic c, input logic w, input logic [1:0] b, input logic [15:0] d);
        @(negedge clk);
        cs = c; wr_en = w; be = b; wdata = d;
        @(negedge clk);
        cs = 0; wr_en = 0; be = 2'b00; wdata = 16'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        exp_err = 0; exp_prot = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check_state("R2 reset", 4'd3, 8'h47);
    endtask

    task automatic t_word_valid();
        do_write(1, 1, 2'b11, 16'h0520);
        check_state("R7 word write", 4'd5, 8'h20);
        do_write(1, 1, 2'b11, 16'h3A40);
        check_state("R4 reserved bits", 4'hA, 8'h40);
    endtask

    task automatic t_range();
        do_write(1, 1, 2'b11, 16'h0130);
        exp_err = 1;
        check_state("R8 Q=1 rejected", 4'hA, 8'h40);
        do_write(1, 1, 2'b11, 16'h0E30);
        check_state("R8 Q=14 rejected", 4'hA, 8'h40);
        do_write(1, 1, 2'b11, 16'h0D30);
        check_state("R8 Q=13 accepted", 4'hD, 8'h30);
        do_write(1, 1, 2'b11, 16'h0506);
        check_state("R8 P=Q+1 rejected", 4'hD, 8'h30);
        do_write(1, 1, 2'b11, 16'h0507);
        check_state("R8 P=Q+2 accepted", 4'd5, 8'h07);
    endtask

    task automatic t_bytes();
        do_write(1, 1, 2'b01, 16'hFF06);
        check_state("R9 low byte vs stored Q rejected", 4'd5, 8'h07);
        do_write(1, 1, 2'b01, 16'h0122);
        check_state("R9 low byte accepted", 4'd5, 8'h22);
        do_write(1, 1, 2'b10, 16'h0C01);
        check_state("R9 high byte accepted", 4'hC, 8'h22);
        do_write(1, 1, 2'b10, 16'h0F99);
        check_state("R9 high byte Q=15 rejected", 4'hC, 8'h22);
    endtask

    task automatic t_no_select();
        do_write(0, 1, 2'b11, 16'h4411);
        check_state("R10 cs low", 4'hC, 8'h22);
        do_write(1, 0, 2'b11, 16'h4411);
        check_state("R10 wr_en low", 4'hC, 8'h22);
    endtask

    task automatic t_lock();
        do_reset();
        do_write(1, 1, 2'b11, 16'h4650);
        exp_prot = 1;
        check_state("R7 lock with new pair", 4'd6, 8'h50);
        do_write(1, 1, 2'b11, 16'h0440);
        check_state("R5 write 0 to protect", 4'd6, 8'h50);
        do_write(1, 1, 2'b11, 16'h4130);
        check_state("R6 locked illegal no error", 4'd6, 8'h50);
        do_write(1, 1, 2'b01, 16'h0060);
        check_state("R6 locked low byte", 4'd6, 8'h50);
        do_reset();
        check_state("R5 reset clears protect", 4'd3, 8'h47);
    endtask

    task automatic t_ref();
        @(negedge clk); ref_slow = 1;
        @(negedge clk);
        check("R1 one edge", {31'h0, rdata[15]}, 32'h0);
        @(negedge clk);
        check("R1 two edges high", {31'h0, rdata[15]}, 32'h1);
        ref_slow = 0;
        @(negedge clk);
        check("R1 one edge fall", {31'h0, rdata[15]}, 32'h1);
        @(negedge clk);
        check("R1 two edges low", {31'h0, rdata[15]}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        t_reset();
        t_word_valid();
        t_range();
        t_bytes();
        t_no_select();
        t_ref();
        t_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule